// File: doc/BRIEF.md
# Pipelined Sum-Product Datapath

This block evaluates (A + B) * (C + D) on a continuous stream of signed operand quadruples and accepts a new quadruple on every clock. The work is split over three register-bounded segments. The first segment registers the four operands. The second segment forms both sums side by side. The third segment multiplies the two sums. Each segment's registers load on every rising edge, and all of them load together.

A valid flag travels alongside each quadruple, one register per segment. Bubbles in the input stream stay visible at the output, and so do the filling and emptying of the pipe. The intermediate sums are one bit wider than the operands. The product is twice the sum width, so every result is exact and no saturation logic is needed. A synchronous reset clears the valid flags only.

Top module: `sum_product_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, every segment's valid flag clears, so `out_valid` is 0 after that edge.
- R2: All four operands are captured on the same edge. Each operand takes part in the result independently of the others, with A and B summed together and C and D summed together.
- R3: Each sum is OPW+1 bits wide and is signed-exact, including when all operands sit at the most negative or most positive value.
- R4: `out_prod` equals (A+B)*(C+D) as a signed 2*(OPW+1)-bit value, with no truncation.
- R5: A quadruple applied before rising edge n appears on `out_prod` with `out_valid` high after rising edge n+2, which is the third edge that sees it.
- R6: n back-to-back valid quadruples produce n consecutive valid results, and the whole run spans 3 + n - 1 clocks from the first input edge to the last result.
- R7: `out_valid` is high only for quadruples that entered with `in_valid` high. An input bubble shows up as a low `out_valid` exactly three edges later.
- R8: Data registers load on every edge whatever the valid flag, so a quadruple applied with `in_valid` low still drives its product onto `out_prod` three edges later, with `out_valid` low.
- R9: A reset pulse during streaming discards every quadruple in flight, including the one applied with the reset, and none of them emerges as valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears valid flags |
| in_valid | input | 1 | Marks the operand quadruple as a real task |
| in_a | input | OPW | Signed operand A |
| in_b | input | OPW | Signed operand B |
| in_c | input | OPW | Signed operand C |
| in_d | input | OPW | Signed operand D |
| out_valid | output | 1 | Result register holds a real task's product |
| out_prod | output | 2*(OPW+1) | Signed product (A+B)*(C+D) |

## Verification
A table of quadruples is streamed back to back. It covers small distinct positive values, which separate operand pairing and ordering faults. It also covers all-minimum and all-maximum operands, which expose a lost sign-extension bit or a narrow product, and mixed signs, which catch unsigned arithmetic. Alternating valid and invalid quadruples show whether the valid flag keeps its position relative to the data, and whether the data path loads independently of it. A reset raised mid-stream shows whether work already in flight is discarded.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int SP_OPERANDS = 4;
  localparam int SP_PAIRS    = SP_OPERANDS / 2;

  // A sum of two w-bit signed values needs one more bit.
  function automatic int sp_sum_width(input int w);
    return w + 1;
  endfunction

  // Product of two sums, each w+1 bits wide.
  function automatic int sp_prod_width(input int w);
    return 2 * (w + 1);
  endfunction

endpackage

// File: rtl/sp_capture_stage.sv
module sp_capture_stage #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [N-1:0][W-1:0]  opnd_i,
  output logic                 valid_q,
  output logic [N-1:0][W-1:0]  opnd_q
);

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_opnd
    always_ff @(posedge clk) begin
      opnd_q[i] <= opnd_i[i];
    end
  end

endmodule

// File: rtl/sp_sum_stage.sv
module sp_sum_stage #(
  parameter int W = 8,
  parameter int P = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid_i,
  input  logic [2*P-1:0][W-1:0]  opnd_i,
  output logic                   valid_q,
  output logic [P-1:0][W:0]      sum_q
);

  function automatic logic [W:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {x[W-1], x} + {y[W-1], y};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_i;
  end

  for (genvar p = 0; p < P; p++) begin : g_pair
    always_ff @(posedge clk) begin
      sum_q[p] <= add_ext(opnd_i[2*p], opnd_i[2*p+1]);
    end
  end

endmodule

// File: rtl/sp_mul_stage.sv
module sp_mul_stage #(
  parameter int SW = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [SW-1:0]   lhs_i,
  input  logic [SW-1:0]   rhs_i,
  output logic            valid_q,
  output logic [2*SW-1:0] prod_q
);

  function automatic logic [2*SW-1:0] mul_ext(input logic [SW-1:0] x, input logic [SW-1:0] y);
    logic signed [2*SW-1:0] xe;
    logic signed [2*SW-1:0] ye;
    xe = {{SW{x[SW-1]}}, x};
    ye = {{SW{y[SW-1]}}, y};
    return xe * ye;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_i;
  end

  always_ff @(posedge clk) begin
    prod_q <= mul_ext(lhs_i, rhs_i);
  end

endmodule

// File: rtl/sum_product_pipe.sv
module sum_product_pipe
  import sp_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  input  logic signed [OPW-1:0]               in_a,
  input  logic signed [OPW-1:0]               in_b,
  input  logic signed [OPW-1:0]               in_c,
  input  logic signed [OPW-1:0]               in_d,
  output logic                                out_valid,
  output logic signed [sp_prod_width(OPW)-1:0] out_prod
);

  localparam int SUMW  = sp_sum_width(OPW);
  localparam int PRODW = sp_prod_width(OPW);

  // Operand order: index 0 = A, 1 = B, 2 = C, 3 = D; pairs (0,1) and (2,3).
  logic [SP_OPERANDS-1:0][OPW-1:0] opnd_in;
  logic [SP_OPERANDS-1:0][OPW-1:0] seg1_opnd;
  logic                            seg1_valid;
  logic [SP_PAIRS-1:0][SUMW-1:0]   seg2_sum;
  logic                            seg2_valid;
  logic [SUMW-1:0]                 seg2_sum_ab;
  logic [SUMW-1:0]                 seg2_sum_cd;
  logic [PRODW-1:0]                prod_raw;

  assign opnd_in[0] = in_a;
  assign opnd_in[1] = in_b;
  assign opnd_in[2] = in_c;
  assign opnd_in[3] = in_d;

  sp_capture_stage #(.W(OPW), .N(SP_OPERANDS)) u_seg1 (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .opnd_i  (opnd_in),
    .valid_q (seg1_valid),
    .opnd_q  (seg1_opnd)
  );

  sp_sum_stage #(.W(OPW), .P(SP_PAIRS)) u_seg2 (
    .clk     (clk),
    .rst     (rst),
    .valid_i (seg1_valid),
    .opnd_i  (seg1_opnd),
    .valid_q (seg2_valid),
    .sum_q   (seg2_sum)
  );

  assign seg2_sum_ab = seg2_sum[0];
  assign seg2_sum_cd = seg2_sum[1];

  sp_mul_stage #(.SW(SUMW)) u_seg3 (
    .clk     (clk),
    .rst     (rst),
    .valid_i (seg2_valid),
    .lhs_i   (seg2_sum_ab),
    .rhs_i   (seg2_sum_cd),
    .valid_q (out_valid),
    .prod_q  (prod_raw)
  );

  assign out_prod = prod_raw;

endmodule

// File: rtl/sum_product_pipe_chk.sv
module sum_product_pipe_chk #(
  parameter int OPW = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      seg1_valid,
  input logic                      seg2_valid,
  input logic                      out_valid,
  input logic [3:0][OPW-1:0]       seg1_opnd,
  input logic [OPW:0]              seg2_sum_ab,
  input logic [OPW:0]              seg2_sum_cd,
  input logic [2*(OPW+1)-1:0]      out_prod
);

  // R1: reset empties every segment
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!seg1_valid && !seg2_valid && !out_valid));

  // R7: the valid flag advances one segment per edge
  a_r7_seg1_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (seg1_valid == $past(in_valid)));

  a_r7_seg2_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (seg2_valid == $past(seg1_valid)));

  a_r7_out_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(seg2_valid)));

  // R3: sums are signed-exact
  a_r3_sum_exact: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (($signed(seg2_sum_ab) == $signed($past(seg1_opnd[0])) + $signed($past(seg1_opnd[1]))) &&
       ($signed(seg2_sum_cd) == $signed($past(seg1_opnd[2])) + $signed($past(seg1_opnd[3])))));

  // R4: product of the previous sums, full width
  a_r4_product_exact: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ($signed(out_prod) == $signed($past(seg2_sum_ab)) * $signed($past(seg2_sum_cd))));

endmodule

bind sum_product_pipe sum_product_pipe_chk #(.OPW(OPW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .seg1_valid  (seg1_valid),
  .seg2_valid  (seg2_valid),
  .out_valid   (out_valid),
  .seg1_opnd   (seg1_opnd),
  .seg2_sum_ab (seg2_sum_ab),
  .seg2_sum_cd (seg2_sum_cd),
  .out_prod    (out_prod)
);

// File: tb/tb_sum_product_pipe.sv
module tb_sum_product_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int OPW   = 8;
  localparam int PRODW = 2 * (OPW + 1);
  localparam int NV    = 8;

  // Stimulus table: a, b, c, d and the expected (a+b)*(c+d), worked out by hand.
  localparam int TA [NV] = '{   1, -128,  127,  127,  -5,   0,  -1,   50};
  localparam int TB [NV] = '{   2, -128,  127,  127,   3,   0,   0,  -20};
  localparam int TC [NV] = '{   3, -128,  127, -128,   7, 100,   0,  -60};
  localparam int TD [NV] = '{   4, -128,  127, -128,  -2,  27,   1,   10};
  localparam int TE [NV] = '{  21, 65536, 64516, -65024, -10, 0, -1, -1500};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [OPW-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic out_valid;
  logic signed [PRODW-1:0] out_prod;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    s = 0;
  bit    hv [256];
  bit    hd [256];
  int    hp [256];
  string ht [256];
  int    first_out = -1;
  int    last_out  = -1;
  int    nvalid_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sum_product_pipe #(.OPW(OPW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at a negedge, pass a posedge, sample at the next negedge.
  task automatic step(input bit v, input bit r, input int a, input int b,
                      input int c, input int d, input string tag);
    hv[s] = v && !r;
    hd[s] = 1'b1;
    hp[s] = (a + b) * (c + d);
    ht[s] = tag;
    if (r) begin
      for (int k = 0; k < 3; k++) begin
        if (s - k >= 0) begin
          hv[s-k] = 1'b0;
          hd[s-k] = 1'b0;
        end
      end
    end
    in_valid = v;
    rst = r;
    in_a = OPW'(a); in_b = OPW'(b); in_c = OPW'(c); in_d = OPW'(d);
    @(posedge clk);
    @(negedge clk);
    if (s >= 2) begin
      chk(out_valid == hv[s-2], {ht[s-2], " valid"}, longint'(out_valid), longint'(hv[s-2]));
      if (hd[s-2])
        chk(int'(out_prod) == hp[s-2], {ht[s-2], " product"}, longint'(int'(out_prod)), longint'(hp[s-2]));
    end
    if (out_valid) begin
      if (first_out < 0) first_out = s;
      last_out = s;
      nvalid_out++;
    end
    s++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 after reset", longint'(out_valid), 0);

    // Table walk, back to back (R2, R3, R4, R5, R6).
    for (int i = 0; i < NV; i++) begin
      step(1'b1, 1'b0, TA[i], TB[i], TC[i], TD[i],
           (i == 0) ? "R5" : (i == 7) ? "R2" : (i >= 1 && i <= 3) ? "R3" : "R4");
      chk((TA[i] + TB[i]) * (TC[i] + TD[i]) == TE[i], "R4 table", (TA[i] + TB[i]) * (TC[i] + TD[i]), TE[i]);
    end
    step(1'b0, 1'b0, 0, 0, 0, 0, "R7");
    step(1'b0, 1'b0, 0, 0, 0, 0, "R7");
    // R6: 8 results in 3 + 8 - 1 = 10 clocks counted from the first input edge
    chk(first_out == 2, "R6 first result", first_out, 2);
    chk(last_out - 0 + 1 == 10, "R6 span", last_out + 1, 10);
    chk(nvalid_out == NV, "R6 count", nvalid_out, NV);

    // Bubbles: invalid quadruples still carry data (R7, R8).
    step(1'b1, 1'b0,  10,  5, -3,  -4, "R7");
    step(1'b0, 1'b0,  -7, -9, 20, 100, "R8");
    step(1'b1, 1'b0, 127, -1,  2,   2, "R7");
    step(1'b0, 1'b0, -128, 0, -128, 0, "R8");
    step(1'b1, 1'b0,   6,  6,  6,   6, "R7");
    step(1'b0, 1'b0,   0,  0,  0,   0, "R7");
    step(1'b0, 1'b0,   0,  0,  0,   0, "R7");

    // Reset mid-stream discards everything in flight (R9).
    step(1'b1, 1'b0, 1, 1, 1, 1, "R9");
    step(1'b1, 1'b0, 2, 2, 2, 2, "R9");
    step(1'b1, 1'b1, 3, 3, 3, 3, "R9");
    step(1'b0, 1'b0, 0, 0, 0, 0, "R9");
    step(1'b0, 1'b0, 0, 0, 0, 0, "R9");
    // After the reset the pipe works again.
    step(1'b1, 1'b0, -3, 4, 5, 6, "R5");
    step(1'b0, 1'b0, 0, 0, 0, 0, "R7");
    step(1'b0, 1'b0, 0, 0, 0, 0, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule